// File: doc/BRIEF.md
# Switching-Period Jump Fault Monitor

This block times the interval between successive switching-cycle start pulses, counted in clock cycles, and compares each new interval with the one before it. When a period grows to more than one and a half times its predecessor, the converter has most likely slipped into continuous conduction. The block then raises an inhibit flag that holds the synchronous-rectifier drive off.

The inhibit stays asserted until a programmable number of consecutive periods (four by default) pass the same ratio test. A period that fails the test during this recovery sends the count back to zero. The most recent measured period is also driven out, so neighbouring logic can use it. The interval counter saturates rather than wrapping. A saturated reading is treated as a jump, because a stalled switching cycle is at least as suspicious as a long one.

Top module: `period_jump_monitor`

## Requirements
- R1: After reset, `drv_inhibit` is 0 and `period_cyc` is 0.
- R2: The first start pulse after reset only arms the block. Each later pulse updates `period_cyc` on the clock edge that samples it, with the number of clock cycles since the previous sampled pulse.
- R3: A new period P raises `drv_inhibit` on its sampling edge when P > Q + (Q >> 1), where Q is the previous period (strictly more than 150% of Q).
- R4: A period exactly equal to Q + (Q >> 1) is a good period and does not raise the inhibit.
- R5: The first measured period after reset has no predecessor and never raises the inhibit, whatever its value.
- R6: While inhibited, the flag clears on the sampling edge of the CLR_CYCLES-th consecutive good period (default 4), and not earlier.
- R7: A failing period during recovery keeps the inhibit set and restarts the good-period count from zero.
- R8: The interval counter saturates at 2^CNT_W-1. A saturated period is reported as that value and counts as a failing period whenever a predecessor exists.
- R9: `drv_inhibit` changes only on clock edges that sample a measured start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-cycle pulse marking the start of a switching cycle |
| drv_inhibit | output | 1 | High: rectifier drive must stay off (period-jump fault active) |
| period_cyc | output | CNT_W | Most recent measured period, in clock cycles |

## Verification
A wrong stored previous period or a corrupted interval count shows up at `period_cyc` on the very next sampled pulse. It also shifts the edge at which `drv_inhibit` rises on a boundary ratio. A good-period counter that is off by one, or that is not cleared by a failing period, appears as an inhibit that drops one or more pulses too early or too late during recovery. A lost armed or predecessor state shows as a spurious inhibit on the first measured period. Each of these differences is visible at the ports within one switching period of the faulty event.

// File: rtl/pjm_pkg.sv
package pjm_pkg;

   // Widest period counter supported by the ratio helper.
   localparam int unsigned PJM_MAX_W = 32;

   // 1.5 x prev computed as prev + prev/2, with headroom so it cannot overflow.
   function automatic logic [PJM_MAX_W:0] ratio_limit(input logic [PJM_MAX_W-1:0] prev);
      logic [PJM_MAX_W:0] ext;
      ext = {1'b0, prev};
      return ext + (ext >> 1);
   endfunction

endpackage

// File: rtl/pjm_period_cnt.sv
module pjm_period_cnt #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic [CNT_W-1:0] cnt,
   output logic             sat
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt <= '0;
      else if (start)           cnt <= CNT_ONE;
      else if (cnt != CNT_MAX)  cnt <= cnt + CNT_ONE;
   end

   assign sat = (cnt == CNT_MAX);

   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sat && !start) |=> sat);   // R8
   AST_START_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt == CNT_ONE));   // R2

endmodule

// File: rtl/pjm_jump_cmp.sv
module pjm_jump_cmp
   import pjm_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic [CNT_W-1:0] cur,
   input  logic             cur_sat,
   input  logic [CNT_W-1:0] prev,
   input  logic             have_prev,
   output logic             jump
);
   logic [PJM_MAX_W:0]   limit;
   logic [PJM_MAX_W-1:0] prev_ext;
   logic [PJM_MAX_W:0]   cur_ext;

   always_comb begin
      prev_ext = '0;
      prev_ext[CNT_W-1:0] = prev;
      cur_ext = '0;
      cur_ext[CNT_W-1:0] = cur;
      limit = ratio_limit(prev_ext);
      jump  = have_prev && (cur_sat || (cur_ext > limit));
   end

   always_comb begin
      if (!have_prev) AST_NO_FIRST_JUMP: assert (!jump);   // R5
   end

endmodule

// File: rtl/pjm_recover.sv
module pjm_recover #(
   parameter int unsigned CLR_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic meas_vld,
   input  logic jump,
   output logic fault
);
   generate
      if (CLR_CYCLES == 1) begin : g_immediate
         always_ff @(posedge clk) begin
            if (!rst_n)        fault <= 1'b0;
            else if (meas_vld) fault <= jump;
         end
      end else begin : g_counted
         localparam int unsigned GW = $clog2(CLR_CYCLES);
         localparam logic [GW-1:0] G_LAST = GW'(CLR_CYCLES - 1);
         logic [GW-1:0] good_cnt;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               fault    <= 1'b0;
               good_cnt <= '0;
            end else if (meas_vld) begin
               if (jump) begin
                  fault    <= 1'b1;
                  good_cnt <= '0;
               end else if (fault) begin
                  if (good_cnt == G_LAST) begin
                     fault    <= 1'b0;
                     good_cnt <= '0;
                  end else begin
                     good_cnt <= good_cnt + GW'(1);
                  end
               end
            end
         end

         AST_GOOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            good_cnt <= G_LAST);   // R6
         AST_BAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
            (meas_vld && jump) |=> (good_cnt == '0));   // R7
      end
   endgenerate

   AST_JUMP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_vld && jump) |=> fault);   // R3
   AST_FAULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !meas_vld |=> $stable(fault));   // R9

endmodule

// File: rtl/period_jump_monitor.sv
module period_jump_monitor #(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned CLR_CYCLES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_start,
   output logic             drv_inhibit,
   output logic [CNT_W-1:0] period_cyc
);
   generate
      if (CNT_W < 4 || CNT_W > pjm_pkg::PJM_MAX_W) begin : g_bad_w
         $error("period_jump_monitor: CNT_W out of range");
      end
      if (CLR_CYCLES < 1) begin : g_bad_clr
         $error("period_jump_monitor: CLR_CYCLES must be at least 1");
      end
   endgenerate

   logic             armed;
   logic             have_prev;
   logic             meas_vld;
   logic             jump;
   logic             cnt_sat;
   logic [CNT_W-1:0] cnt;

   assign meas_vld = cyc_start && armed;

   pjm_period_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .start (cyc_start),
      .cnt   (cnt),
      .sat   (cnt_sat)
   );

   pjm_jump_cmp #(.CNT_W(CNT_W)) u_cmp (
      .cur       (cnt),
      .cur_sat   (cnt_sat),
      .prev      (period_cyc),
      .have_prev (have_prev),
      .jump      (jump)
   );

   pjm_recover #(.CLR_CYCLES(CLR_CYCLES)) u_rec (
      .clk      (clk),
      .rst_n    (rst_n),
      .meas_vld (meas_vld),
      .jump     (jump),
      .fault    (drv_inhibit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed      <= 1'b0;
         have_prev  <= 1'b0;
         period_cyc <= '0;
      end else begin
         if (cyc_start) armed <= 1'b1;
         if (meas_vld) begin
            have_prev  <= 1'b1;
            period_cyc <= cnt;
         end
      end
   end

   AST_FIRST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_vld && !have_prev) |=> !drv_inhibit);   // R5
   AST_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      meas_vld |=> (period_cyc != '0));   // R2

endmodule

// File: tb/test_period_jump_monitor.sv
module test_period_jump_monitor;
   localparam int unsigned W    = 8;
   localparam int unsigned CLR  = 4;
   localparam int unsigned PMAX = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cyc_start = 1'b0;
   logic         drv_inhibit;
   logic [W-1:0] period_cyc;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model
   bit m_armed = 0, m_have = 0, m_fault = 0;
   int m_prev = 0, m_good = 0;

   always #5 clk = ~clk;

   period_jump_monitor #(.CNT_W(W), .CLR_CYCLES(CLR)) i_period_jump_monitor (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
      .drv_inhibit(drv_inhibit), .period_cyc(period_cyc)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic bit is_jump(input int p, input int q, input bit have);
      if (!have) return 0;
      if (p >= PMAX) return 1;
      return (2 * p) > (3 * q);
   endfunction

   // update model for a pulse that closes an interval of p cycles
   task automatic model_pulse(input int p);
      int meas;
      bit j;
      if (!m_armed) begin
         m_armed = 1;
         return;
      end
      meas = (p >= PMAX) ? PMAX : p;
      j = is_jump(p, m_prev, m_have);
      if (j) begin
         m_fault = 1; m_good = 0;
      end else if (m_fault) begin
         if (m_good == CLR - 1) begin m_fault = 0; m_good = 0; end
         else m_good++;
      end
      m_have = 1;
      m_prev = meas;
   endtask

   // pulse p cycles after previous pulse; checks result of previous pulse first
   task automatic send(input int p, input string req);
      @(negedge clk);
      check({req, " period"}, int'(period_cyc), m_prev);
      check({req, " inhibit"}, int'(drv_inhibit), int'(m_fault));
      cyc_start = 1'b0;
      for (int i = 0; i < p - 2; i++) begin
         @(negedge clk);
         if (i == 1) check("R9 inhibit stable mid-gap", int'(drv_inhibit), int'(m_fault));
      end
      @(negedge clk);
      cyc_start = 1'b1;
      model_pulse(p);
   endtask

   initial begin
      int p;
      int seed;
      seed = 1234;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      check("R1 inhibit", int'(drv_inhibit), 0);
      check("R1 period", int'(period_cyc), 0);
      rst_n = 1'b1;

      send(7, "R2 arm");          // first pulse only arms
      send(250, "R2");            // first measurement, huge, R5
      send(20, "R5 first");       // after first: check no fault from 250
      send(30, "R2");             // exactly 150% of 20 -> good (R4)
      send(46, "R4 boundary");    // 46 > 45 -> jump (R3)
      send(40, "R3 jump");
      send(40, "R6 good1");
      send(40, "R6 good2");
      send(61, "R6 good3");       // 61 > 60 -> bad during recovery (R7)
      send(50, "R7 bad");
      send(50, "R7 good1");
      send(50, "R7 good2");
      send(50, "R6 good3 still set");
      send(30, "R6 cleared");     // check clear after 4th good
      send(300, "R6");            // saturates (R8)
      send(100, "R8 saturated");  // 100 vs 255 good
      // random mix
      for (int k = 0; k < 120; k++) begin
         p = (m_prev * (50 + int'($urandom_range(0, 130)))) / 100;
         if ($urandom_range(0, 19) == 0) p = 260;
         if (p < 2) p = 2;
         if (p > 280) p = 280;
         send(p, "R3 random");
      end
      send(5, "R6 random tail");
      @(negedge clk);
      cyc_start = 1'b0;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule